// File: doc/BRIEF.md
# Revolution Ripple-Clock Generator

This block watches the value of an up-down position counter and raises a ripple marker whenever the count crosses its major carry: a step from all ones to all zeros when counting up, or from all zeros to all ones when counting down. Each such crossing stands for one completed revolution or pitch of the tracked input. The counter value, the step strobe that accompanies every counter increment or decrement (`busy`), the direction flag and the output-latch inhibit are inputs. The counter and the step-pulse generator live outside the block.

The marker is timed against the step strobe. It stays high for at least `MIN_HI` clock cycles. It also stays high until the step pulse that came with the crossing has ended, and it then drops before the next step pulse begins. If the direction flips while the marker is high, the marker is held until the direction has stayed unchanged across two further step-strobe rising edges. This suppresses a dither around the carry point. A crossing that arrives while the marker is already high starts a fresh episode.

For an external revolution counter, the block also gives a registered one-cycle event. It is the marker qualified by the step strobe, and it carries the crossing's direction. The event is withheld while inhibit is asserted, because the qualification is not trustworthy in that state. The marker itself ignores inhibit.

Top module: `revRippleGen`

## Requirements
- R1: After reset `ripple`, `revEvent` and `revDir` are 0, and the first counter value sampled after reset is never treated as a crossing.
- R2: When `posCount` moves from all ones to all zeros, `ripple` is 1 from the next clock edge, and `revDir` becomes 0 (up).
- R3: When `posCount` moves from all zeros to all ones, `ripple` is 1 from the next clock edge, and `revDir` becomes 1 (down).
- R4: Any other change of `posCount`, including jumps between non-adjacent values, and a value that does not change, raise neither `ripple` nor `revEvent`.
- R5: Once raised, `ripple` stays high for at least `MIN_HI` clock cycles, even when the step pulse is shorter. With a one-cycle step pulse it is high for exactly `MIN_HI` cycles.
- R6: `ripple` clears on the first clock edge at which all of the following hold: the minimum width has elapsed, a high step strobe has been seen during the episode, `busy` is low, and no hold is pending. Therefore it is low again before the following step pulse when pulses are spaced by more than `MIN_HI` cycles.
- R7: If `dirDown` changes while `ripple` is high, `ripple` stays high until `dirDown` has remained unchanged across two `busy` rising edges. A direction change resets that count.
- R8: `revEvent` is a registered single-cycle pulse, asserted once per episode, in the first cycle in which `ripple` and `busy` are both high.
- R9: `inhibitN` low has no effect on `ripple`, and it suppresses `revEvent` for the episode.
- R10: A crossing while `ripple` is already high restarts the episode. It yields a new `revEvent`, updates `revDir` and restarts the minimum-width count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| posCount | input | POS_W | Current value of the up-down position counter |
| busy | input | 1 | Step strobe, high while a counter step is being signalled |
| dirDown | input | 1 | Counting direction, 1 = down |
| inhibitN | input | 1 | Output-latch inhibit, active low; gates only the event output |
| ripple | output | 1 | Ripple marker, high after a major-carry crossing |
| revEvent | output | 1 | One-cycle revolution event for an external counter |
| revDir | output | 1 | Direction of the latest crossing, 1 = down |

## Verification
A wrong carry comparison shows up one edge after the offending counter step: `ripple` and `revEvent` either appear on an ordinary step or fail to appear on a crossing. A faulty width counter or clear condition shows up in the cycle `ripple` falls, because the marker drops before `MIN_HI` cycles have passed or stays high past the step pulse. A broken direction hold is visible only after a direction flip at the carry, as a marker that drops too soon or too late relative to the second stable step edge. The sweep covers every pair of counter values on a three-bit counter, so any stray crossing decode is exposed within a single step.

// File: rtl/revRipplePkg.sv
package revRipplePkg;

  // Status observed by the datapath and consumed by the control.
  typedef struct packed {
    logic wrapUp;      // all ones -> all zeros seen this cycle
    logic wrapDown;    // all zeros -> all ones seen this cycle
    logic busyRise;    // step strobe rising edge
    logic dirChange;   // direction differs from last cycle
    logic widthDone;   // marker has been high for the minimum width
    logic stableDone;  // enough stable step edges since last direction change
  } dpStatus_t;

  // Strobes issued by the control to the datapath.
  typedef struct packed {
    logic loadWidth;   // start a new width count
    logic countWidth;  // advance the width count
    logic clrStable;   // restart the stable-edge count
    logic incStable;   // one more stable step edge
  } ctlStrobe_t;

endpackage

// File: rtl/revRippleDp.sv
module revRippleDp
  import revRipplePkg::*;
#(
  parameter int POS_W        = 16,
  parameter int MIN_HI       = 15,
  parameter int STABLE_EDGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [POS_W-1:0] posCount,
  input  logic             busy,
  input  logic             dirDown,
  input  ctlStrobe_t       stb,
  output dpStatus_t        st
);

  localparam int WCW = $clog2(MIN_HI + 1);
  localparam int SCW = $clog2(STABLE_EDGES + 1);
  localparam logic [WCW-1:0]   WIDTH_LIM  = WCW'(MIN_HI);
  localparam logic [SCW-1:0]   STABLE_LIM = SCW'(STABLE_EDGES);
  localparam logic [POS_W-1:0] ALL_ONES   = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] ALL_ZEROS  = '0;

  logic [POS_W-1:0] prevCount;
  logic             prevValid;
  logic             busyPrev;
  logic             dirPrev;
  logic [WCW-1:0]   widthCnt;
  logic [SCW-1:0]   stableCnt;

  // Sampled history of the inputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCount <= '0;
      prevValid <= 1'b0;
      busyPrev  <= 1'b0;
      dirPrev   <= 1'b0;
    end else begin
      prevCount <= posCount;
      prevValid <= 1'b1;
      busyPrev  <= busy;
      dirPrev   <= dirDown;
    end
  end

  // Marker width counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthCnt <= '0;
    end else if (stb.loadWidth) begin
      widthCnt <= WCW'(1);
    end else if (stb.countWidth && (widthCnt < WIDTH_LIM)) begin
      widthCnt <= widthCnt + WCW'(1);
    end
  end

  // Stable-direction step edge counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stableCnt <= '0;
    end else if (stb.clrStable) begin
      stableCnt <= '0;
    end else if (stb.incStable && (stableCnt < STABLE_LIM)) begin
      stableCnt <= stableCnt + SCW'(1);
    end
  end

  always_comb begin
    st            = '0;
    st.wrapUp     = prevValid && (prevCount == ALL_ONES)  && (posCount == ALL_ZEROS);
    st.wrapDown   = prevValid && (prevCount == ALL_ZEROS) && (posCount == ALL_ONES);
    st.busyRise   = busy && !busyPrev;
    st.dirChange  = prevValid && (dirDown != dirPrev);
    st.widthDone  = (widthCnt >= WIDTH_LIM);
    st.stableDone = (stableCnt >= STABLE_LIM);
  end

  // R5: the width count never runs past its limit
  a_r5_width_bounded: assert property (@(posedge clk) disable iff (!rstN)
    widthCnt <= WIDTH_LIM)
    else $error("width counter beyond limit");

  // R7: a direction change always restarts the stable count
  a_r7_stable_restart: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrStable |=> (stableCnt == '0))
    else $error("stable count not restarted");

endmodule

// File: rtl/revRippleCtl.sv
module revRippleCtl
  import revRipplePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busy,
  input  logic       inhibitN,
  input  dpStatus_t  st,
  output ctlStrobe_t stb,
  output logic       ripple,
  output logic       revEvent,
  output logic       revDir
);

  logic seenBusy;
  logic armed;
  logic holdOff;
  logic wrapNow;
  logic holdEff;
  logic clearNow;
  logic rippleNext;

  assign wrapNow    = st.wrapUp || st.wrapDown;
  assign holdEff    = holdOff && !st.stableDone;
  assign clearNow   = ripple && !wrapNow && st.widthDone && seenBusy && !busy && !holdEff;
  assign rippleNext = wrapNow ? 1'b1 : (clearNow ? 1'b0 : ripple);

  always_comb begin
    stb            = '0;
    stb.loadWidth  = wrapNow;
    stb.countWidth = ripple;
    stb.clrStable  = st.dirChange;
    stb.incStable  = st.busyRise && !st.dirChange;
  end

  // Marker, step-seen flag and direction hold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ripple   <= 1'b0;
      seenBusy <= 1'b0;
      holdOff  <= 1'b0;
      revDir   <= 1'b0;
    end else begin
      ripple <= rippleNext;
      if (wrapNow) begin
        seenBusy <= busy;
        revDir   <= st.wrapDown;
      end else if (ripple && busy) begin
        seenBusy <= 1'b1;
      end
      if (!rippleNext) begin
        holdOff <= 1'b0;
      end else if (ripple && st.dirChange) begin
        holdOff <= 1'b1;
      end else if (holdOff && st.stableDone) begin
        holdOff <= 1'b0;
      end
    end
  end

  // Qualified revolution event, one per episode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      revEvent <= 1'b0;
    end else begin
      revEvent <= 1'b0;
      if (wrapNow) begin
        if (busy) begin
          revEvent <= inhibitN;
          armed    <= 1'b0;
        end else begin
          armed    <= 1'b1;
        end
      end else if (armed && ripple && busy) begin
        revEvent <= inhibitN;
        armed    <= 1'b0;
      end else if (!ripple) begin
        armed    <= 1'b0;
      end
    end
  end

  // R2/R3: the marker only rises after a carry crossing
  a_r2_rise_on_wrap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ripple) |-> $past(st.wrapUp || st.wrapDown))
    else $error("marker rose without a crossing");

  // R5: the marker only falls after the minimum width
  a_r5_min_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ripple) |-> $past(st.widthDone))
    else $error("marker shorter than minimum width");

  // R6: the marker never falls while the step strobe was high
  a_r6_clear_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ripple) |-> !$past(busy))
    else $error("marker cleared during a step pulse");

  // R7: a pending direction hold keeps the marker high
  a_r7_hold_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (ripple && holdOff && !st.stableDone) |=> ripple)
    else $error("marker cleared during direction hold");

  // R8: an event only appears while the marker is high
  a_r8_event_in_marker: assert property (@(posedge clk) disable iff (!rstN)
    revEvent |-> ripple)
    else $error("event outside marker");

  // R9: no event when inhibit was asserted
  a_r9_event_gated: assert property (@(posedge clk) disable iff (!rstN)
    revEvent |-> $past(inhibitN))
    else $error("event while inhibited");

endmodule

// File: rtl/revRippleGen.sv
module revRippleGen
  import revRipplePkg::*;
#(
  parameter int POS_W        = 16,
  parameter int MIN_HI       = 15,
  parameter int STABLE_EDGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [POS_W-1:0] posCount,
  input  logic             busy,
  input  logic             dirDown,
  input  logic             inhibitN,
  output logic             ripple,
  output logic             revEvent,
  output logic             revDir
);

  dpStatus_t  dpSt;
  ctlStrobe_t ctlStb;

  revRippleDp #(
    .POS_W       (POS_W),
    .MIN_HI      (MIN_HI),
    .STABLE_EDGES(STABLE_EDGES)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .posCount(posCount),
    .busy    (busy),
    .dirDown (dirDown),
    .stb     (ctlStb),
    .st      (dpSt)
  );

  revRippleCtl uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .busy    (busy),
    .inhibitN(inhibitN),
    .st      (dpSt),
    .stb     (ctlStb),
    .ripple  (ripple),
    .revEvent(revEvent),
    .revDir  (revDir)
  );

endmodule

// File: tb/sim_revRippleGen.sv
module sim_revRippleGen;

  localparam int W    = 3;
  localparam int MINH = 4;
  localparam int TOP  = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] posCount = '0;
  logic         busy = 1'b0;
  logic         dirDown = 1'b0;
  logic         inhibitN = 1'b1;
  logic         ripple;
  logic         revEvent;
  logic         revDir;

  int checks = 0;
  int failures = 0;
  int lastCount = 0;

  always #10 clk = ~clk;

  revRippleGen #(.POS_W(W), .MIN_HI(MINH)) u0 (
    .clk(clk), .rstN(rstN), .posCount(posCount), .busy(busy),
    .dirDown(dirDown), .inhibitN(inhibitN),
    .ripple(ripple), .revEvent(revEvent), .revDir(revDir)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
    end
  endtask

  // Drive one counter step with a step pulse of hb cycles and gap gl cycles.
  task automatic step(input int val, input logic d, input int hb, input int gl,
                      input bit chkFirst, input bit chkEnd);
    int isUp;
    int isDown;
    isUp   = (lastCount == TOP && val == 0) ? 1 : 0;
    isDown = (lastCount == 0 && val == TOP) ? 1 : 0;
    @(negedge clk);
    posCount = W'(val);
    dirDown  = d;
    busy     = 1'b1;
    lastCount = val;
    @(negedge clk);
    if (chkFirst) begin
      if (isUp != 0) chk("R2 ripple on up crossing", int'(ripple), 1);
      else if (isDown != 0) chk("R3 ripple on down crossing", int'(ripple), 1);
      else chk("R4 no ripple on ordinary step", int'(ripple), 0);
      chk("R8/R9 event on crossing", int'(revEvent), ((isUp | isDown) != 0 && inhibitN) ? 1 : 0);
      if (isUp != 0) chk("R2 direction up", int'(revDir), 0);
      if (isDown != 0) chk("R3 direction down", int'(revDir), 1);
    end
    for (int k = 1; k < hb; k++) @(negedge clk);
    busy = 1'b0;
    for (int k = 0; k < gl; k++) @(negedge clk);
    if (chkEnd) chk("R6 ripple low before next step", int'(ripple), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 ripple in reset", int'(ripple), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 ripple after reset", int'(ripple), 0);
    chk("R1 event after reset", int'(revEvent), 0);
    chk("R1 direction after reset", int'(revDir), 0);

    // R2 R3 R4 R8: every ordered pair of counter values
    for (int a = 0; a <= TOP; a++) begin
      for (int b = 0; b <= TOP; b++) begin
        step(a, 1'b0, 2, 6, 1'b1, 1'b1);
        step(b, 1'b0, 2, 6, 1'b1, 1'b1);
      end
    end

    // R8: event is a single cycle
    step(TOP, 1'b0, 2, 6, 1'b1, 1'b1);
    step(0, 1'b0, 3, 0, 1'b1, 1'b0);
    chk("R8 event lasts one cycle", int'(revEvent), 0);
    repeat (8) @(negedge clk);

    // R5: one-cycle step pulse, ripple high exactly MINH cycles
    step(TOP, 1'b0, 2, 6, 1'b1, 1'b1);
    step(0, 1'b0, 1, 0, 1'b1, 1'b0);
    for (int k = 2; k <= MINH + 2; k++) begin
      @(negedge clk);
      chk("R5 minimum width", int'(ripple), (k <= MINH) ? 1 : 0);
    end

    // R6: long step pulse keeps the marker until it ends
    step(TOP, 1'b0, 2, 6, 1'b1, 1'b1);
    step(0, 1'b0, 8, 0, 1'b1, 1'b0);
    chk("R6 held during long pulse", int'(ripple), 1);
    @(negedge clk);
    chk("R6 cleared after pulse ends", int'(ripple), 0);
    repeat (4) @(negedge clk);

    // R9: inhibit leaves the marker alone and blocks the event
    inhibitN = 1'b0;
    step(TOP, 1'b0, 2, 6, 1'b1, 1'b1);
    step(0, 1'b0, 2, 6, 1'b1, 1'b1);
    step(TOP, 1'b1, 2, 6, 1'b1, 1'b1);
    inhibitN = 1'b1;

    // R7 R10: direction flip at the carry
    step(TOP - 1, 1'b0, 2, 6, 1'b1, 1'b1);
    step(TOP, 1'b0, 2, 6, 1'b1, 1'b1);
    step(0, 1'b0, 1, 0, 1'b1, 1'b0);
    dirDown = 1'b1;
    repeat (MINH + 4) @(negedge clk);
    chk("R7 held after direction change", int'(ripple), 1);
    step(TOP, 1'b1, 1, 0, 1'b0, 1'b0);
    chk("R10 restart ripple", int'(ripple), 1);
    repeat (MINH + 4) @(negedge clk);
    chk("R10 restart direction", int'(revDir), 1);
    chk("R7 held after one stable edge", int'(ripple), 1);
    step(TOP - 1, 1'b1, 1, 0, 1'b0, 1'b0);
    chk("R7 still high on second stable edge", int'(ripple), 1);
    @(negedge clk);
    chk("R7 cleared after two stable edges", int'(ripple), 0);
    repeat (4) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule